// File: doc/BRIEF.md
# Switched-Capacitor Filter Clock Generator

This block turns a crystal reference clock into the sampling phases of a switched-capacitor low-pass filter. A programmable first stage divides the reference by a 6-bit setting. A fixed four-slot rotation then hands one pulse in turn to each of four phase outputs, so the filter sees four non-overlapping phases. The complete phase sequence repeats every four first-stage periods. With this ratio, the filter corner lands at the reference frequency divided by forty times the setting. For example, a 16 MHz reference with a setting of 4 gives a 100 kHz corner.

Software programs the block through one 8-bit configuration register, reached on a write port with a 7-bit address. The register holds the divide setting and a doubling control. The same register can be read back on a combinational read port. A setting of zero parks the phase outputs low. A new setting never cuts short the divide period that is already under way, so no runt pulse can reach the filter.

Top module: `scf_clkgen`

## Requirements
- R1: After reset, all four phase outputs and the valid flag are low, and the configuration register reads 8'h80.
- R2: A write to address 7'h08 stores wr_data_i[6] as the doubling bit and wr_data_i[5:0] as the divide setting. Reading address 7'h08 returns {1'b1, doubling bit, setting}, with bit 7 always 1 whatever was written to it. Reading any other address returns 8'h00.
- R3: While running with the doubling bit clear, the effective ratio r equals the setting. Each phase stays high for exactly r reference cycles, and the order is phase_o[0], phase_o[1], phase_o[2], phase_o[3], then back to phase_o[0].
- R4: With the doubling bit set and a setting of 2 or more, r is the setting shifted right by one (floor of half). With a setting of 1, the doubling bit has no effect and r is 1.
- R5: A setting of 0 stops the block. After the current divide period ends, phase_o and phase_vld_o are low and stay low.
- R6: phase_o is one-hot while phase_vld_o is high and all-zero while it is low, so no two phases are ever high together.
- R7: Starting from the stopped state, phase_o[0] rises one cycle after the register update, that is, after the second rising edge counted from the write edge.
- R8: A setting written while running takes effect only when the current divide period ends. The phase that is high completes its full old length, and the next phase uses the new ratio.
- R9: A write to any address other than 7'h08 changes neither the register contents nor the phase outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 7 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 7 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| phase_o | output | 4 | One-hot filter clock phases |
| phase_vld_o | output | 1 | High while the phases are running |

## Verification
A write is captured on its rising edge, and readback follows combinationally in the next half cycle. Starting from idle, phase_o[0] appears one further edge later. After that, every phase change falls exactly r cycles after the previous one, and a mid-period rewrite only shows after the old period has run its remaining cycles. The driver computes this timeline from the requirements and queues one expected phase/valid pair per cycle. The monitor pops one entry every cycle, 1 ns after the falling edge, so every comparison lines up with the cycle in which the result is due.

// File: rtl/scf_clkgen_pkg.sv
`timescale 1ns/1ps
package scf_clkgen_pkg;
    localparam int                 SCF_ADDR_W   = 7;
    localparam int                 SCF_DATA_W   = 8;
    localparam int                 SCF_DIV_W    = 6;
    localparam int                 SCF_NPH      = 4;
    localparam logic [SCF_ADDR_W-1:0] SCF_CFG_ADDR = 7'h08;
endpackage

// File: rtl/scf_cfg_reg.sv
`timescale 1ns/1ps
module scf_cfg_reg #(
    parameter int                ADDR_W   = 7,
    parameter int                DATA_W   = 8,
    parameter int                DIV_W    = 6,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 7'h08
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              x2_o
);
    localparam int PAD_W = DATA_W - DIV_W - 2;

    typedef struct packed {
        logic             x2;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i && (wr_addr_i == CFG_ADDR)) begin
            cfg_d.x2  = wr_data_i[DIV_W];
            cfg_d.div = wr_data_i[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data_o = (rd_addr_i == CFG_ADDR)
                             ? {1'b1, {PAD_W{1'b0}}, cfg_q.x2, cfg_q.div}
                             : '0;
        end else begin : g_nopad
            assign rd_data_o = (rd_addr_i == CFG_ADDR)
                             ? {1'b1, cfg_q.x2, cfg_q.div}
                             : '0;
        end
    endgenerate

    assign div_o = cfg_q.div;
    assign x2_o  = cfg_q.x2;
endmodule

// File: rtl/scf_prediv.sv
`timescale 1ns/1ps
module scf_prediv #(
    parameter int DIV_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             x2_i,
    output logic             start_o,
    output logic             step_o,
    output logic             halt_o,
    output logic [DIV_W-1:0] cnt_o,
    output logic [DIV_W-1:0] ratio_o
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] ratio;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DIV_W-1:0] eff_ratio;
    logic             end_cyc;

    always_comb begin
        eff_ratio = (x2_i && (div_i > ONE)) ? (div_i >> 1) : div_i;
        end_cyc   = !st_q.run || (st_q.cnt == (st_q.ratio - ONE));
        st_d      = st_q;
        start_o   = 1'b0;
        step_o    = 1'b0;
        halt_o    = 1'b0;
        if (end_cyc) begin
            st_d.cnt   = '0;
            st_d.ratio = eff_ratio;
            st_d.run   = (eff_ratio != '0);
            if (st_q.run) begin
                step_o = (eff_ratio != '0);
                halt_o = (eff_ratio == '0);
            end else begin
                start_o = (eff_ratio != '0);
            end
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign ratio_o = st_q.ratio;
endmodule

// File: rtl/scf_phase_gen.sv
`timescale 1ns/1ps
module scf_phase_gen #(
    parameter int NPH = 4
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           start_i,
    input  logic           step_i,
    input  logic           halt_i,
    output logic [NPH-1:0] phase_o,
    output logic           vld_o
);
    localparam logic [NPH-1:0] FIRST = {{(NPH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic           vld;
        logic [NPH-1:0] ph;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (halt_i) begin
            st_d = '0;
        end else if (start_i) begin
            st_d.vld = 1'b1;
            st_d.ph  = FIRST;
        end else if (step_i) begin
            st_d.ph = {st_q.ph[NPH-2:0], st_q.ph[NPH-1]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign phase_o = st_q.ph;
    assign vld_o   = st_q.vld;
endmodule

// File: rtl/scf_clkgen.sv
`timescale 1ns/1ps
module scf_clkgen
    import scf_clkgen_pkg::*;
#(
    parameter int                ADDR_W   = SCF_ADDR_W,
    parameter int                DATA_W   = SCF_DATA_W,
    parameter int                DIV_W    = SCF_DIV_W,
    parameter int                NPH      = SCF_NPH,
    parameter logic [ADDR_W-1:0] CFG_ADDR = SCF_CFG_ADDR
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [NPH-1:0]    phase_o,
    output logic              phase_vld_o
);
    logic [DIV_W-1:0] cfg_div;
    logic             cfg_x2;
    logic             div_start, div_step, div_halt;
    logic [DIV_W-1:0] div_cnt, div_ratio;

    scf_cfg_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .CFG_ADDR(CFG_ADDR)
    ) u_cfg (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .div_o(cfg_div), .x2_o(cfg_x2)
    );

    scf_prediv #(.DIV_W(DIV_W)) u_prediv (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .div_i(cfg_div), .x2_i(cfg_x2),
        .start_o(div_start), .step_o(div_step), .halt_o(div_halt),
        .cnt_o(div_cnt), .ratio_o(div_ratio)
    );

    scf_phase_gen #(.NPH(NPH)) u_phase (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .start_i(div_start), .step_i(div_step), .halt_i(div_halt),
        .phase_o(phase_o), .vld_o(phase_vld_o)
    );
endmodule

// File: rtl/scf_clkgen_chk.sv
`timescale 1ns/1ps
module scf_clkgen_chk #(
    parameter int                ADDR_W   = 7,
    parameter int                DATA_W   = 8,
    parameter int                DIV_W    = 6,
    parameter int                NPH      = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 7'h08
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [NPH-1:0]    phase,
    input logic              vld,
    input logic [DIV_W-1:0]  cfg_div,
    input logic [DIV_W-1:0]  cnt,
    input logic [DIV_W-1:0]  ratio
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    // R6: phases never overlap, valid tracks activity
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase) && (vld == (phase != '0)));

    // R3: every change while running is a one-step rotation
    a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vld) && vld && (phase != $past(phase)))
        |-> (phase == {$past(phase[NPH-2:0]), $past(phase[NPH-1])}));

    // R8: a running phase only changes at the end of its divide period
    a_r8_change_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vld) && (phase != $past(phase)))
        |-> ($past(cnt) == ($past(ratio) - ONE)));

    // R5: stopped with a zero setting stays stopped
    a_r5_stay_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld && (cfg_div == '0)) |=> !vld);

    // R2: fixed upper bit on readback
    a_r2_fixed_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == CFG_ADDR) |-> rd_data[DATA_W-1]);
endmodule

bind scf_clkgen scf_clkgen_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .NPH(NPH), .CFG_ADDR(CFG_ADDR)
) i_chk (
    .clk(clk_i), .rst_n(rst_ni),
    .rd_addr(rd_addr_i), .rd_data(rd_data_o),
    .phase(phase_o), .vld(phase_vld_o),
    .cfg_div(cfg_div), .cnt(div_cnt), .ratio(div_ratio)
);

// File: tb/test_scf_clkgen.sv
`timescale 1ns/1ps
module test_scf_clkgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [3:0] phase;
    logic       vld;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic       vld;
        logic [3:0] ph;
        string      req;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    scf_clkgen i_scf_clkgen (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .phase_o(phase), .phase_vld_o(vld)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic v, input logic [3:0] p, input string req, input int n);
        item_t it;
        it.vld = v; it.ph = p; it.req = req;
        for (int i = 0; i < n; i++) sb_q.push_back(it);
    endtask

    task automatic push_period(input int r, input string req);
        push(1'b1, 4'b0001, req, r);
        push(1'b1, 4'b0010, req, r);
        push(1'b1, 4'b0100, req, r);
        push(1'b1, 4'b1000, req, r);
    endtask

    task automatic wait_empty();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // reset, program from idle, expect one idle cycle (R7) then np periods
    task automatic run_idle(input logic [7:0] d, input int r, input int np, input string req);
        do_reset();
        wr(7'h08, d);
        push(1'b0, 4'b0000, "R7", 1);
        for (int k = 0; k < np; k++) push_period(r, req);
        wait_empty();
    endtask

    // monitor: one expected item per cycle
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() != 0) begin
                it = sb_q.pop_front();
                n_chk++;
                if ({vld, phase} !== {it.vld, it.ph}) begin
                    n_fail++;
                    $display("FAIL %s: actual vld=%b phase=%b expected vld=%b phase=%b",
                             it.req, vld, phase, it.vld, it.ph);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        #1;
        chk("R1 phase", {4'b0, phase}, 8'h00);
        chk("R1 vld", {7'b0, vld}, 8'h00);
        rd_addr = 7'h08;
        #1;
        chk("R1 readback", rd_data, 8'h80);

        // R9 write elsewhere ignored
        wr(7'h09, 8'h05);
        push(1'b0, 4'b0000, "R9", 6);
        wait_empty();
        rd_addr = 7'h08;
        #1;
        chk("R9 readback", rd_data, 8'h80);
        rd_addr = 7'h09;
        #1;
        chk("R2 other address", rd_data, 8'h00);
        rd_addr = 7'h08;

        // R3 plain ratios, R6 one-hot via every item
        run_idle(8'h01, 1, 3, "R3,R6");
        run_idle(8'h03, 3, 2, "R3,R6");
        run_idle(8'h04, 4, 1, "R3,R6");
        run_idle(8'h3F, 63, 1, "R3,R6");

        // R4 doubling
        run_idle(8'h46, 3, 1, "R4");
        run_idle(8'h41, 1, 2, "R4");
        run_idle(8'h45, 2, 2, "R4");
        run_idle(8'h47, 3, 1, "R4");
        #1;
        chk("R2 fixed bit7 readback", rd_data, 8'hC7);

        // R8 mid-period change 5 -> 2
        run_idle(8'h05, 5, 1, "R8");
        wr(7'h08, 8'h02);
        push(1'b1, 4'b0001, "R8", 4);
        push(1'b1, 4'b0010, "R8", 2);
        push(1'b1, 4'b0100, "R8", 2);
        push(1'b1, 4'b1000, "R8", 2);
        push(1'b1, 4'b0001, "R8", 2);
        wait_empty();

        // R5 stop at end of period
        run_idle(8'h04, 4, 1, "R5");
        wr(7'h08, 8'h00);
        push(1'b1, 4'b0001, "R5", 3);
        push(1'b0, 4'b0000, "R5", 5);
        wait_empty();
        #1;
        chk("R2 readback zero setting", rd_data, 8'h80);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule